// File: doc/BRIEF.md
# Counter Threshold Window Comparator

This block sorts three values against a pair of thresholds: the live value of a counter and the contents of two capture registers. Each value falls into one of three zones: under the lower threshold, inside the window between the thresholds, or over it. The result is kept in a 16-bit status word that holds one one-hot 3-bit group per value. The counter, the capture logic and the bus that reads the word are outside the block. The block only observes their values and strobes.

An enable input clears the word when it is low. A suspend input freezes the word, so software can rewrite both thresholds without disturbing the reported state. Comparisons resume with the new thresholds once suspend drops. The capture groups follow their load strobes. The counter group is refreshed by a trigger set that depends on the counting mode. That set draws on an internal millisecond tick, a ten-millisecond tick, a period-end strobe, a user interval strobe, counter reload, return-to-zero and stop strobes, and a zone change of the counter itself. An upper threshold that is not strictly above the lower one is ignored. The order of both thresholds can be signed or unsigned, to match the counter format.

Top module: `thresh_zone_cmp`

## Requirements
- R1: With a valid window (upper > lower), a value below lower gives Low, a value from lower to upper inclusive gives Window, and a value above upper gives High.
- R2: When upper <= lower, upper is ignored: a value below lower gives Low, any other value gives High, and Window is never set.
- R3: With `signed_fmt`=1 the threshold check and all comparisons treat the values as two's complement; with 0 they are unsigned.
- R4: Status bit layout: [8:6] capture 1, [5:3] capture 0, [2:0] counter; in each group bit 2 is High, bit 1 Window, bit 0 Low. Bits [15:9] are always 0, and every group holds at most one set bit. After reset the word is 0.
- R5: A pulse on `cap0_load` or `cap1_load` updates that capture's group in the next cycle. Other groups are left alone.
- R6: `enable`=0 clears the whole word in the next cycle. The clear wins over `suspend`.
- R7: While `suspend`=1 the word holds its value, whatever the triggers or threshold writes. After release, comparisons use the thresholds present at that moment.
- R8: Mode encodings: 0 frequency, 1 period, 2 ratio, 3 event, 4 one-shot, 5 modulo, 6 free large, 7 PWM. In modes 0 and 2 the counter group updates only on the ten-millisecond tick, every 10*CYC_PER_MS cycles.
- R9: In mode 1 the counter group updates only on `period_end`. In mode 3 it updates only on `user_tick`.
- R10: In modes 4 to 6 the counter group updates on the millisecond tick (every CYC_PER_MS cycles), on `cnt_reload`, and on a change of the counter's zone. `cnt_stop` triggers in modes 4 and 5 only, and `cnt_zero` in mode 5 only.
- R11: In mode 7 the word is cleared in the next cycle and stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Counting mode (see R8) |
| signed_fmt | input | 1 | 1: values are two's complement |
| enable | input | 1 | 0 clears the status word |
| suspend | input | 1 | 1 freezes the status word |
| lo_thr | input | DW | Lower threshold |
| hi_thr | input | DW | Upper threshold |
| cnt_val | input | DW | Live counter value |
| cap0_val | input | DW | Capture register 0 value |
| cap0_load | input | 1 | Capture 0 load strobe |
| cap1_val | input | DW | Capture register 1 value |
| cap1_load | input | 1 | Capture 1 load strobe |
| period_end | input | 1 | End of a measured period |
| user_tick | input | 1 | User-defined interval strobe |
| cnt_reload | input | 1 | Counter reload strobe |
| cnt_zero | input | 1 | Counter return-to-zero strobe |
| cnt_stop | input | 1 | Counter stop strobe |
| status | output | 16 | Zone status word |

## Verification
The checker watches the word's shape on every cycle: unused bits stay 0 and each group is one-hot or empty. It also checks the clear after a low enable or PWM mode, the hold while suspended, and that a capture load always leaves exactly one zone bit in that group. The zone arithmetic needs the bench's directed scenarios. This covers the window edges, an ignored upper threshold and signed versus unsigned order. The scenarios also show which trigger refreshes the counter group in which mode, and the tick intervals. The bench exposes these by freezing a stale counter group and then applying a single trigger.

// File: rtl/tzc_pkg.sv
package tzc_pkg;
  localparam int GROUPS = 3;
  localparam int ZW     = 3;
  localparam int SW     = 16;

  typedef enum logic [2:0] {
    M_FREQ      = 3'd0,
    M_PERIOD    = 3'd1,
    M_RATIO     = 3'd2,
    M_EVENT     = 3'd3,
    M_ONESHOT   = 3'd4,
    M_MODULO    = 3'd5,
    M_FREELARGE = 3'd6,
    M_PWM       = 3'd7
  } cnt_mode_e;

  typedef struct packed {
    logic high;
    logic win;
    logic low;
  } zone_t;
endpackage

// File: rtl/tzc_tick_gen.sv
module tzc_tick_gen #(
  parameter int CYC_PER_MS = 100000,
  parameter int MS_PER_SLOW = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick_ms,
  output logic tick_slow
);
  localparam int CW = $clog2(CYC_PER_MS + 1);
  localparam int MW = $clog2(MS_PER_SLOW + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_MS - 1);
  localparam logic [MW-1:0] MS_LAST  = MW'(MS_PER_SLOW - 1);

  logic [CW-1:0] cyc_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q     <= '0;
      ms_q      <= '0;
      tick_ms   <= 1'b0;
      tick_slow <= 1'b0;
    end else begin
      tick_ms   <= (cyc_q == CYC_LAST);
      cyc_q     <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
      tick_slow <= tick_ms && (ms_q == MS_LAST);
      if (tick_ms) ms_q <= (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
    end
  end
endmodule

// File: rtl/tzc_zone_cls.sv
module tzc_zone_cls
  import tzc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic          is_signed,
  output zone_t         zone
);
  logic signed [DW:0] v_s, lo_s, hi_s;
  logic valid, below, above;

  always_comb begin
    v_s   = {is_signed & value[DW-1], value};
    lo_s  = {is_signed & lo[DW-1], lo};
    hi_s  = {is_signed & hi[DW-1], hi};
    valid = hi_s > lo_s;
    below = v_s < lo_s;
    above = valid ? (v_s > hi_s) : !below;
    zone.low  = below;
    zone.high = above;
    zone.win  = valid && !below && !above;
  end
endmodule

// File: rtl/tzc_trig_sel.sv
module tzc_trig_sel
  import tzc_pkg::*;
(
  input  cnt_mode_e mode,
  input  logic      tick_ms,
  input  logic      tick_slow,
  input  logic      period_end,
  input  logic      user_tick,
  input  logic      cnt_reload,
  input  logic      cnt_zero,
  input  logic      cnt_stop,
  input  logic      crossing,
  output logic      cnt_upd
);
  always_comb begin
    unique case (mode)
      M_FREQ, M_RATIO: cnt_upd = tick_slow;
      M_PERIOD:        cnt_upd = period_end;
      M_EVENT:         cnt_upd = user_tick;
      M_ONESHOT:       cnt_upd = tick_ms | cnt_reload | cnt_stop | crossing;
      M_MODULO:        cnt_upd = tick_ms | cnt_reload | cnt_zero | cnt_stop | crossing;
      M_FREELARGE:     cnt_upd = tick_ms | cnt_reload | crossing;
      default:         cnt_upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/thresh_zone_cmp.sv
module thresh_zone_cmp
  import tzc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CYC_PER_MS = 100000,
  parameter int MS_PER_SLOW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode,
  input  logic          signed_fmt,
  input  logic          enable,
  input  logic          suspend,
  input  logic [DW-1:0] lo_thr,
  input  logic [DW-1:0] hi_thr,
  input  logic [DW-1:0] cnt_val,
  input  logic [DW-1:0] cap0_val,
  input  logic          cap0_load,
  input  logic [DW-1:0] cap1_val,
  input  logic          cap1_load,
  input  logic          period_end,
  input  logic          user_tick,
  input  logic          cnt_reload,
  input  logic          cnt_zero,
  input  logic          cnt_stop,
  output logic [15:0]   status
);
  localparam int GW = GROUPS * ZW;

  cnt_mode_e mode_e;
  logic tick_ms, tick_slow, cnt_upd, crossing, clear_all, hold_all;
  logic [DW-1:0] vals [GROUPS];
  logic [GROUPS-1:0] upd;
  zone_t zones [GROUPS];
  zone_t cnt_prev_q;
  logic [GW-1:0] grp_flat;

  assign mode_e    = cnt_mode_e'(mode);
  assign vals[0]   = cnt_val;
  assign vals[1]   = cap0_val;
  assign vals[2]   = cap1_val;
  assign clear_all = !enable || (mode_e == M_PWM);
  assign hold_all  = suspend;
  assign crossing  = (zones[0] != cnt_prev_q);
  assign upd       = {cap1_load, cap0_load, cnt_upd};

  tzc_tick_gen #(.CYC_PER_MS(CYC_PER_MS), .MS_PER_SLOW(MS_PER_SLOW)) u_tick (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .tick_slow(tick_slow)
  );

  tzc_trig_sel u_trig (
    .mode(mode_e), .tick_ms(tick_ms), .tick_slow(tick_slow),
    .period_end(period_end), .user_tick(user_tick), .cnt_reload(cnt_reload),
    .cnt_zero(cnt_zero), .cnt_stop(cnt_stop), .crossing(crossing),
    .cnt_upd(cnt_upd)
  );

  always_ff @(posedge clk) begin
    if (rst) cnt_prev_q <= '0;
    else     cnt_prev_q <= zones[0];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    zone_t grp_q;

    tzc_zone_cls #(.DW(DW)) u_cls (
      .value(vals[g]), .lo(lo_thr), .hi(hi_thr),
      .is_signed(signed_fmt), .zone(zones[g])
    );

    always_ff @(posedge clk) begin
      if (rst || clear_all)     grp_q <= '0;
      else if (!hold_all && upd[g]) grp_q <= zones[g];
    end

    assign grp_flat[g*ZW +: ZW] = grp_q;
  end

  assign status = {{(SW-GW){1'b0}}, grp_flat};
endmodule

// File: rtl/tzc_checker.sv
module tzc_checker (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  mode,
  input logic        enable,
  input logic        suspend,
  input logic        cap0_load,
  input logic [15:0] status
);
  a_r4_layout: assert property (@(posedge clk) disable iff (rst)
    status[15:9] == 7'd0 && $onehot0(status[8:6]) &&
    $onehot0(status[5:3]) && $onehot0(status[2:0]));

  a_r6_clear_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !enable |=> status == 16'd0);

  a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
    (enable && suspend && mode != 3'd7) |=> $stable(status));

  a_r11_pwm_clear: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd7) |=> status == 16'd0);

  a_r5_cap0_zone: assert property (@(posedge clk) disable iff (rst)
    (cap0_load && enable && !suspend && mode != 3'd7) |=> $countones(status[5:3]) == 1);
endmodule

bind thresh_zone_cmp tzc_checker u_tzc_chk (
  .clk(clk), .rst(rst), .mode(mode), .enable(enable), .suspend(suspend),
  .cap0_load(cap0_load), .status(status)
);

// File: tb/thresh_zone_cmp_bench.sv
module thresh_zone_cmp_bench;
  localparam int DW  = 16;
  localparam int CPM = 20;

  logic clk = 0, rst = 1;
  logic [2:0] mode = 3'd3;
  logic signed_fmt = 0, enable = 0, suspend = 0;
  logic [DW-1:0] lo_thr = 16'd100, hi_thr = 16'd200, cnt_val = 16'd0;
  logic [DW-1:0] cap0_val = 0, cap1_val = 0;
  logic cap0_load = 0, cap1_load = 0, period_end = 0, user_tick = 0;
  logic cnt_reload = 0, cnt_zero = 0, cnt_stop = 0;
  logic [15:0] status;
  int checks = 0, errors = 0;

  thresh_zone_cmp #(.DW(DW), .CYC_PER_MS(CPM), .MS_PER_SLOW(10)) u_thresh_zone_cmp (
    .clk(clk), .rst(rst), .mode(mode), .signed_fmt(signed_fmt), .enable(enable),
    .suspend(suspend), .lo_thr(lo_thr), .hi_thr(hi_thr), .cnt_val(cnt_val),
    .cap0_val(cap0_val), .cap0_load(cap0_load), .cap1_val(cap1_val),
    .cap1_load(cap1_load), .period_end(period_end), .user_tick(user_tick),
    .cnt_reload(cnt_reload), .cnt_zero(cnt_zero), .cnt_stop(cnt_stop),
    .status(status)
  );

  always #5 clk = ~clk;

  localparam logic [2:0] LOW = 3'b001, WIN = 3'b010, HIGH = 3'b100;

  function automatic logic [2:0] zone_ref(input logic [DW-1:0] v, lo, hi, input logic sg);
    logic signed [DW:0] a, l, h;
    a = {sg & v[DW-1], v}; l = {sg & lo[DW-1], lo}; h = {sg & hi[DW-1], hi};
    if (a < l) return LOW;
    if (h > l) return (a > h) ? HIGH : WIN;
    return HIGH;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load0(input logic [DW-1:0] v);
    cap0_val = v; cap0_load = 1; step(1); cap0_load = 0;
  endtask

  task automatic load1(input logic [DW-1:0] v);
    cap1_val = v; cap1_load = 1; step(1); cap1_load = 0;
  endtask

  // Change counter while frozen so the counter group is left stale.
  task automatic stale_cnt(input logic [DW-1:0] v);
    suspend = 1; step(1); cnt_val = v; step(1); suspend = 0;
  endtask

  // Wait until the counter group changes; returns cycles waited.
  task automatic wait_cnt(input int maxc, output int n);
    logic [2:0] old;
    old = status[2:0];
    n = 0;
    for (int i = 1; i <= maxc; i++) begin
      step(1);
      if (status[2:0] != old) begin n = i; break; end
    end
  endtask

  task automatic t_reset;
    chk("R4 reset", status, 16'd0);
  endtask

  task automatic t_capture;
    mode = 3'd3; enable = 1; lo_thr = 100; hi_thr = 200; signed_fmt = 0; step(2);
    load0(16'd50);
    chk("R5 cap0 low", status[5:3], LOW);
    load1(16'd150);
    chk("R1 cap1 window", status[8:6], WIN);
    chk("R5 cap0 untouched", status[5:3], LOW);
    load0(16'd200);
    chk("R1 upper edge window", status[5:3], WIN);
    load0(16'd100);
    chk("R1 lower edge window", status[5:3], WIN);
    load0(16'd201);
    chk("R1 high", status[5:3], HIGH);
    chk("R4 layout", status, {7'd0, WIN, HIGH, 3'b000});
  endtask

  task automatic t_invalid;
    lo_thr = 100; hi_thr = 100;
    load0(16'd150); chk("R2 equal thr high", status[5:3], HIGH);
    load0(16'd100); chk("R2 at lower high", status[5:3], HIGH);
    load0(16'd99);  chk("R2 below lower", status[5:3], LOW);
    hi_thr = 50;
    load0(16'd75);  chk("R2 upper ignored", status[5:3], zone_ref(16'd75, 16'd100, 16'd50, 1'b0));
  endtask

  task automatic t_signed;
    lo_thr = 16'hFFF6; hi_thr = 16'h000A; signed_fmt = 1;
    load0(16'hFFFF); chk("R3 signed window", status[5:3], WIN);
    signed_fmt = 0;
    load0(16'hFFFF); chk("R3 unsigned high", status[5:3], HIGH);
    lo_thr = 16'h0005; hi_thr = 16'hFFFF; signed_fmt = 1;
    load0(16'h0100); chk("R3 signed invalid thr", status[5:3], HIGH);
    signed_fmt = 0;
    load0(16'h0100); chk("R3 unsigned valid thr", status[5:3], WIN);
    lo_thr = 100; hi_thr = 200;
  endtask

  task automatic t_event_period;
    mode = 3'd3; cnt_val = 50; step(1);
    user_tick = 1; step(1); user_tick = 0;
    chk("R9 event user tick", status[2:0], LOW);
    cnt_val = 150; step(300);
    chk("R9 event no timed update", status[2:0], LOW);
    user_tick = 1; step(1); user_tick = 0;
    chk("R9 event update", status[2:0], WIN);
    mode = 3'd1; cnt_val = 250; step(300);
    chk("R9 period waits", status[2:0], WIN);
    period_end = 1; step(1); period_end = 0;
    chk("R9 period end update", status[2:0], HIGH);
  endtask

  task automatic t_suspend;
    load0(16'd50);
    suspend = 1; lo_thr = 10; hi_thr = 20; step(1);
    load0(16'd15);
    chk("R7 frozen on load", status[5:3], LOW);
    user_tick = 1; step(1); user_tick = 0;
    chk("R7 frozen on trigger", status[2:0], HIGH);
    suspend = 0; step(1);
    load0(16'd15);
    chk("R7 new thresholds", status[5:3], WIN);
    lo_thr = 100; hi_thr = 200;
  endtask

  task automatic t_timed(input logic [2:0] m);
    int n;
    mode = m; cnt_val = 50; step(1);
    stale_cnt(16'd150);
    wait_cnt(10*CPM + 5, n);
    chk("R8 sync update", status[2:0], WIN);
    stale_cnt(16'd250);
    cnt_reload = 1; user_tick = 1; period_end = 1; step(1);
    cnt_reload = 0; user_tick = 0; period_end = 0;
    chk("R8 other strobes ignored", status[2:0], WIN);
    wait_cnt(10*CPM + 5, n);
    chk("R8 slow tick update", status[2:0], HIGH);
    chk("R8 interval", 16'(n >= 10*CPM - 8 && n <= 10*CPM), 16'd1);
  endtask

  task automatic sync_fast(input logic [2:0] m);
    int n;
    mode = m; cnt_val = 50; step(CPM + 2);
    stale_cnt(16'd150);
    wait_cnt(CPM + 5, n);
    chk("R10 ms tick update", status[2:0], WIN);
    chk("R10 ms interval", 16'(n >= 1 && n <= CPM), 16'd1);
    stale_cnt(16'd250);
  endtask

  task automatic t_fast;
    sync_fast(3'd4);
    cnt_zero = 1; step(1); cnt_zero = 0;
    chk("R10 one-shot zero ignored", status[2:0], WIN);
    cnt_stop = 1; step(1); cnt_stop = 0;
    chk("R10 one-shot stop", status[2:0], HIGH);

    sync_fast(3'd5);
    cnt_zero = 1; step(1); cnt_zero = 0;
    chk("R10 modulo zero", status[2:0], HIGH);

    sync_fast(3'd6);
    cnt_zero = 1; cnt_stop = 1; step(1); cnt_zero = 0; cnt_stop = 0;
    chk("R10 free zero/stop ignored", status[2:0], WIN);
    cnt_reload = 1; step(1); cnt_reload = 0;
    chk("R10 free reload", status[2:0], HIGH);
    cnt_val = 50; step(1);
    chk("R10 crossing", status[2:0], LOW);
  endtask

  task automatic t_disable_pwm;
    mode = 3'd3; load1(16'd150);
    suspend = 1; enable = 0; step(1);
    chk("R6 clear over suspend", status, 16'd0);
    suspend = 0; enable = 1; step(3);
    chk("R6 stays clear", status, 16'd0);
    load0(16'd150);
    mode = 3'd7; step(1);
    chk("R11 pwm clears", status, 16'd0);
    load0(16'd150); cnt_reload = 1; step(1); cnt_reload = 0;
    chk("R11 pwm stays clear", status, 16'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3); rst = 0; step(1);
    t_reset();
    t_capture();
    t_invalid();
    t_signed();
    t_event_period();
    t_suspend();
    t_timed(3'd0);
    t_timed(3'd2);
    t_fast();
    t_disable_pwm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule